// File: doc/BRIEF.md
# Eight-bit Arithmetic/Logic Unit with Status Flag Update

This block is the combinational datapath of a small 8-bit processor core. Decode logic outside it supplies two operands, a carry input, an operation code and the current status byte. The block returns the operation's result and a new status byte. Each operation rewrites only its own set of flags. Every other flag bit is copied through from the incoming status byte, so software can chain operations: multi-byte adds and subtracts, and compares that span several bytes.

The status byte layout is fixed because the neighbouring decode and branch logic reads it by position. Bits 7 down to 0 hold I, T, H, S, V, N, Z, C. The block never alters I or T. The half-carry H reports the carry out of the low nibble on additions and the borrow into bit 4 on subtractions. Compare operations use the subtract codes; the caller simply discards the result.

Top module: `alu8_status`

## Requirements
- R1: Codes 0 (add) and 1 (add plus carry_i) give result = a+b(+carry_i) mod 256. C is the carry out of bit 7. H is the carry out of bit 3. V is set when a and b have equal sign and the result's sign differs. Z, N and S are also written.
- R2: Codes 2 (subtract) and 3 (subtract minus carry_i) give result = a-b(-carry_i) mod 256. C is set on borrow. H is the borrow into bit 4. V is set when a and b differ in sign and the result's sign differs from a.
- R3: For code 3, Z becomes 0 when the result is non-zero. Otherwise Z keeps its incoming value (status bit 1).
- R4: Codes 4 (AND), 5 (OR) and 6 (XOR) write Z, N and S. They clear V and keep C and H.
- R5: Codes 9 (a+1) and 10 (a-1) write Z, N, V and S. V is set only for input 0x7F (increment) or 0x80 (decrement). C and H are kept.
- R6: Code 7 returns 0xFF-a with C=1 and V=0, and keeps H. Code 8 returns 0x00-a and writes all of H, S, V, N, Z, C, using the subtract rules of R2.
- R7: Shifts fill as follows. Code 11 fills bit 0 with 0. Code 12 fills bit 7 with 0. Code 13 fills bit 0 with carry_i. Code 14 fills bit 7 with carry_i. Code 15 keeps bit 7. The bit shifted out goes to C. H is kept.
- R8: For shift codes 11 to 15, V = N xor C of the new values.
- R9: Code 16 exchanges the two nibbles of a and returns the status byte unchanged.
- R10: Whenever N or V is written, S (status bit 4) equals N xor V of the new status.
- R11: Status bits 7 (I) and 6 (T) always pass through unchanged. Codes 17 to 31 return 0 and leave the status byte unchanged.
- R12: Every operation that writes Z, except code 3, sets Z (bit 1) exactly when the result is 0. N (bit 2) equals result bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry input for add/subtract with carry and rotates |
| op_i | input | 5 | Operation code |
| sreg_i | input | 8 | Incoming status byte (I,T,H,S,V,N,Z,C from bit 7) |
| result_o | output | 8 | Operation result |
| sreg_o | output | 8 | Updated status byte |

## Verification
The inline assertions watch every evaluation for the relations that hold regardless of operand values. These are: the S = N xor V identity, I and T passing through, the nibble swap leaving the status untouched, the carry and half-carry being kept by the logical operations, the fixed C and V values of the one's complement, and the zero flag tracking a zero result. The exact arithmetic only appears in the bench scenarios: carries and borrows at the 0x7F/0x80/0xFF boundaries, the half-carry across the nibble edge, the fill bits of each shift, and the sticky zero across chained subtracts. The bench therefore drives hand-computed corner values and a pseudo-random sweep against an independent model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 5;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_AND  = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7,
    OP_NEG  = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_LSL = 5'd11,
    OP_LSR  = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;

  // bit order matches status bits 5..0
  typedef struct packed {
    logic h, s, v, n, z, c;
  } flag_set_t;

  function automatic flag_set_t upd_mask(alu_op_e op);
    flag_set_t m;
    m = '0;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
        m = '{h: 1'b1, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
        m = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b0};
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:
        m = '{h: 1'b0, s: 1'b1, v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic is_arith(alu_op_e op);
    return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC};
  endfunction

  function automatic logic is_shift(alu_op_e op);
    return op inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR};
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         h_o,
  output logic         v_o
);
  localparam int HB = W / 2;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;
  logic [HB:0]  low;

  // subtract as a + ~b + ~borrow; carry out inverts to borrow
  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ? ~cin_i : cin_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, a_i[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, c_eff};
    sum_o = full[W-1:0];
    c_o   = full[W] ^ sub_i;
    h_o   = low[HB] ^ sub_i;
    v_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  localparam int HB = W / 2;

  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  begin res_o = ~a_i; c_o = 1'b1; end
      OP_LSL:  begin res_o = {a_i[W-2:0], 1'b0};      c_o = a_i[W-1]; end
      OP_LSR:  begin res_o = {1'b0, a_i[W-1:1]};      c_o = a_i[0];   end
      OP_ROL:  begin res_o = {a_i[W-2:0], cin_i};     c_o = a_i[W-1]; end
      OP_ROR:  begin res_o = {cin_i, a_i[W-1:1]};     c_o = a_i[0];   end
      OP_ASR:  begin res_o = {a_i[W-1], a_i[W-1:1]};  c_o = a_i[0];   end
      OP_SWAP: res_o = {a_i[HB-1:0], a_i[W-1:HB]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] res_i,
  input  logic         ar_c_i,
  input  logic         ar_h_i,
  input  logic         ar_v_i,
  input  logic         bit_c_i,
  input  logic [7:0]   sreg_i,
  output logic [7:0]   sreg_o
);
  flag_set_t mask, nxt;
  logic      arith, shift, zero;

  always_comb begin
    mask  = upd_mask(op_i);
    arith = is_arith(op_i);
    shift = is_shift(op_i);
    zero  = (res_i == '0);

    nxt.n = res_i[W-1];
    nxt.c = arith ? ar_c_i : bit_c_i;
    nxt.h = ar_h_i;
    if (arith)      nxt.v = ar_v_i;
    else if (shift) nxt.v = res_i[W-1] ^ bit_c_i;
    else            nxt.v = 1'b0;
    nxt.s = nxt.n ^ nxt.v;
    // chained subtract keeps a clear Z across bytes
    nxt.z = (op_i == OP_SBC) ? (zero & sreg_i[FL_Z]) : zero;

    sreg_o[7:6] = sreg_i[7:6];
    sreg_o[5:0] = (nxt & mask) | (sreg_i[5:0] & ~mask);
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            carry_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [7:0]      sreg_i,
  output logic [W-1:0]    result_o,
  output logic [7:0]      sreg_o
);
  alu_op_e      op;
  logic [W-1:0] add_a, add_b, add_sum, bit_res;
  logic         add_cin, add_sub, add_c, add_h, add_v, bit_c;

  always_comb begin
    op      = alu_op_e'(op_i);
    add_a   = a_i;
    add_b   = b_i;
    add_cin = 1'b0;
    add_sub = 1'b0;
    case (op)
      OP_ADC: add_cin = carry_i;
      OP_SUB: add_sub = 1'b1;
      OP_SBC: begin add_sub = 1'b1; add_cin = carry_i; end
      OP_INC: add_b = W'(1);
      OP_DEC: begin add_b = W'(1); add_sub = 1'b1; end
      OP_NEG: begin add_a = '0; add_b = a_i; add_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i(add_a), .b_i(add_b), .cin_i(add_cin), .sub_i(add_sub),
    .sum_o(add_sum), .c_o(add_c), .h_o(add_h), .v_o(add_v)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .a_i(a_i), .b_i(b_i), .cin_i(carry_i), .op_i(op),
    .res_o(bit_res), .c_o(bit_c)
  );

  assign result_o = is_arith(op) ? add_sum : bit_res;

  alu8_flags #(.W(W)) u_flags (
    .op_i(op), .res_i(result_o), .ar_c_i(add_c), .ar_h_i(add_h),
    .ar_v_i(add_v), .bit_c_i(bit_c), .sreg_i(sreg_i), .sreg_o(sreg_o)
  );

  always_comb begin
    assert_it_pass_R11: assert (sreg_o[7:6] == sreg_i[7:6])
      else $error("I/T flags altered");
    if (op_i > 5'd16)
      assert_undef_keep_R11: assert (sreg_o == sreg_i && result_o == '0)
        else $error("undefined code changed state");
    if (op == OP_SWAP)
      assert_swap_keep_R9: assert (sreg_o == sreg_i && result_o == {a_i[3:0], a_i[7:4]})
        else $error("swap wrong");
    if (op inside {OP_AND, OP_OR, OP_XOR})
      assert_logic_keep_R4: assert (sreg_o[FL_C] == sreg_i[FL_C] &&
                                    sreg_o[FL_H] == sreg_i[FL_H] && !sreg_o[FL_V])
        else $error("logic op flags wrong");
    if (op == OP_COM)
      assert_com_flags_R6: assert (sreg_o[FL_C] && !sreg_o[FL_V])
        else $error("complement flags wrong");
    if (op_i <= 5'd15)
      assert_sign_R10: assert (sreg_o[FL_S] == (sreg_o[FL_N] ^ sreg_o[FL_V]))
        else $error("S != N^V");
    if (op_i <= 5'd15 && op != OP_SBC)
      assert_zero_R12: assert (sreg_o[FL_Z] == (result_o == '0) &&
                               sreg_o[FL_N] == result_o[W-1])
        else $error("Z/N mismatch");
    if (op == OP_SBC && !sreg_i[FL_Z])
      assert_sbc_sticky_R3: assert (!sreg_o[FL_Z])
        else $error("chained Z set");
  end
endmodule

// File: tb/alu8_status_bench.sv
module alu8_status_bench;
  logic       clk = 1'b0;
  logic [7:0] a, b, sreg_in, res, sreg_out;
  logic       cin;
  logic [4:0] op;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;
  bit         done   = 0;

  always #10 clk = ~clk;

  alu8_status u_alu8_status (
    .a_i(a), .b_i(b), .carry_i(cin), .op_i(op), .sreg_i(sreg_in),
    .result_o(res), .sreg_o(sreg_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic apply(input int o, input int av, input int bv, input int c, input int s);
    @(negedge clk);
    op = 5'(o); a = 8'(av); b = 8'(bv); cin = c[0]; sreg_in = 8'(s);
    #2;
  endtask

  task automatic expect_v(input string tag, input int er, input int es);
    checks++;
    if (res !== 8'(er) || sreg_out !== 8'(es)) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: actual res=%h sreg=%h expected res=%h sreg=%h",
               tag, op, a, b, res, sreg_out, 8'(er), 8'(es));
    end
  endtask

  // independent model built from the requirement text; returns {res, sreg}
  function automatic int model(int o, int av, int bv, int c, int s);
    int r, cf, hf, vf, nf, zf, sf, msk, ns;
    r = 0; cf = 0; hf = 0; vf = 0; msk = 0;
    case (o)
      0, 1: begin
        int ci = (o == 1) ? c : 0;
        r  = av + bv + ci;
        cf = r > 255; r = r & 255;
        hf = ((av & 15) + (bv & 15) + ci) > 15;
        vf = ((av ^ r) & (bv ^ r) & 128) != 0;
        msk = 'h3F;
      end
      2, 3, 8: begin
        int x = (o == 8) ? 0 : av;
        int y = (o == 8) ? av : bv;
        int ci = (o == 3) ? c : 0;
        cf = x < y + ci;
        hf = (x & 15) < (y & 15) + ci;
        r  = (x - y - ci) & 255;
        vf = ((x ^ y) & (x ^ r) & 128) != 0;
        msk = 'h3F;
      end
      4: begin r = av & bv; msk = 'h1E; end
      5: begin r = av | bv; msk = 'h1E; end
      6: begin r = av ^ bv; msk = 'h1E; end
      7: begin r = 255 - av; cf = 1; msk = 'h1F; end
      9:  begin r = (av + 1) & 255; vf = (av == 'h7F); msk = 'h1E; end
      10: begin r = (av - 1) & 255; vf = (av == 'h80); msk = 'h1E; end
      11: begin r = (av * 2) & 255;             cf = av >> 7; msk = 'h1F; end
      12: begin r = av / 2;                     cf = av & 1;  msk = 'h1F; end
      13: begin r = ((av * 2) & 255) | c;       cf = av >> 7; msk = 'h1F; end
      14: begin r = (av / 2) | (c * 128);       cf = av & 1;  msk = 'h1F; end
      15: begin r = (av / 2) | (av & 128);      cf = av & 1;  msk = 'h1F; end
      16: r = ((av & 15) * 16) | (av / 16);
      default: r = 0;
    endcase
    nf = (r >> 7) & 1;
    zf = (r == 0);
    if (o == 3) zf = zf & ((s >> 1) & 1);
    if (o >= 11 && o <= 15) vf = nf ^ cf;
    sf = nf ^ vf;
    ns = (hf << 5) | (sf << 4) | (vf << 3) | (nf << 2) | (zf << 1) | cf;
    ns = (s & ~msk) | (ns & msk);
    return (r << 8) | (ns & 255);
  endfunction

  task automatic check_model(input string tag, input int o, input int av,
                             input int bv, input int c, input int s);
    int m;
    apply(o, av, bv, c, s);
    m = model(o, av, bv, c, s);
    expect_v(tag, m >> 8, m & 255);
  endtask

  task automatic t_idle;
    apply(0, 0, 0, 0, 0);
    expect_v("R12 idle zero add", 'h00, 'h02);
  endtask

  task automatic t_add;
    apply(0, 'h0F, 'h01, 0, 0);   expect_v("R1 half carry", 'h10, 'h20);
    apply(0, 'h7F, 'h01, 0, 0);   expect_v("R1 overflow",   'h80, 'h2C);
    apply(0, 'hFF, 'h01, 0, 0);   expect_v("R1 carry out",  'h00, 'h23);
    apply(1, 'h10, 'h20, 1, 0);   expect_v("R1 adc",        'h31, 'h00);
  endtask

  task automatic t_sub;
    apply(2, 'h00, 'h01, 0, 0);   expect_v("R2 borrow",     'hFF, 'h35);
    apply(3, 'h10, 'h0F, 1, 0);   expect_v("R2 sbc",        'h00, 'h20);
    apply(3, 'h05, 'h05, 0, 'h00); expect_v("R3 sticky clear", 'h00, 'h00);
    apply(3, 'h05, 'h05, 0, 'h02); expect_v("R3 keep set",  'h00, 'h02);
    apply(3, 'h06, 'h05, 0, 'h02); expect_v("R3 clear nz",  'h01, 'h00);
  endtask

  task automatic t_logic;
    apply(4, 'hF0, 'h0F, 0, 'h29); expect_v("R4 and keep C H", 'h00, 'h23);
    apply(5, 'h80, 'h01, 0, 'h08); expect_v("R4 or",           'h81, 'h14);
    apply(6, 'hAA, 'hAA, 0, 'h21); expect_v("R4 xor",          'h00, 'h23);
  endtask

  task automatic t_incdec;
    apply(9,  'h7F, 0, 0, 'h21);  expect_v("R5 inc overflow", 'h80, 'h2D);
    apply(10, 'h80, 0, 0, 'h00);  expect_v("R5 dec overflow", 'h7F, 'h18);
    apply(9,  'hFF, 0, 0, 'h00);  expect_v("R5 inc wrap keeps C", 'h00, 'h02);
  endtask

  task automatic t_comneg;
    apply(7, 'hFF, 0, 0, 'h20);   expect_v("R6 com", 'h00, 'h23);
    apply(8, 'h80, 0, 0, 'h00);   expect_v("R6 neg 0x80", 'h80, 'h0D);
    apply(8, 'h00, 0, 0, 'h01);   expect_v("R6 neg zero", 'h00, 'h02);
  endtask

  task automatic t_shift;
    apply(11, 'h80, 0, 1, 0);     expect_v("R7 R8 lsl", 'h00, 'h1B);
    apply(12, 'h01, 0, 1, 0);     expect_v("R7 R8 lsr", 'h00, 'h1B);
    apply(13, 'h40, 0, 1, 0);     expect_v("R7 R8 rol", 'h81, 'h0C);
    apply(14, 'h01, 0, 1, 0);     expect_v("R7 R8 ror", 'h80, 'h15);
    apply(15, 'h81, 0, 0, 0);     expect_v("R7 R8 asr", 'hC0, 'h15);
  endtask

  task automatic t_swap_misc;
    apply(16, 'hA5, 0, 1, 'hFF);  expect_v("R9 swap", 'h5A, 'hFF);
    apply(17, 'h12, 'h34, 1, 'hA5); expect_v("R11 undefined code", 'h00, 'hA5);
    apply(31, 'hFF, 'hFF, 1, 'h3C); expect_v("R11 top code", 'h00, 'h3C);
    apply(0, 'h01, 'h01, 0, 'hC0); expect_v("R11 I T pass", 'h02, 'hC0);
    apply(4, 'h80, 'hFF, 0, 'h08); expect_v("R10 S from N", 'h80, 'h14);
  endtask

  task automatic t_sweep;
    logic [31:0] lf = 32'h1ACE_B00C;
    for (int o = 0; o < 18; o++) begin
      for (int k = 0; k < 40; k++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        check_model("R1-sweep model (R2 R4 R6 R7 R10 R12)", o,
                    int'(lf[7:0]), int'(lf[15:8]), int'(lf[16]), int'(lf[31:24]));
      end
    end
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; op = '0; sreg_in = '0;
    repeat (2) @(negedge clk);
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_incdec();
    t_comneg();
    t_shift();
    t_swap_misc();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule